// File: doc/BRIEF.md
# Floating-point control register access unit

This unit serves the move-from and move-to floating-point control instructions of a 32-bit core. A read strobe selects one control register by number. The unit then returns the selected value, packed or extended as that register requires. A write strobe either updates the packed control/status fields or acts on the floating-point register pairing mode bit (FR) of the processor status.

Two otherwise unused control register numbers act as aliases that let user code read, clear or set FR. The alias only works when the implementation word advertises the feature and a configuration enable is on. When the feature is advertised but not enabled, the access raises a reserved-instruction exception pulse instead. All results appear one clock after the strobe, as registered update requests for the surrounding core. The unit stores no architectural state of its own.

Top module: `fpctl_access`

## Requirements
- R1: While reset is asserted, every output is zero.
- R2: Reading number 0 returns the 32-bit implementation word, sign-extended to XLEN, on `rd_data` with `rd_vld` high one cycle after the strobe.
- R3: Reading number 1 when bit 28 of the implementation word and `sw_enable` are both 1 returns `fr_cur` in bit 0, with all other bits 0.
- R4: Reading number 1 when implementation bit 28 is 1 and `sw_enable` is 0 gives an `exc_ri` pulse, with `rd_vld` low and `rd_data` unchanged.
- R5: Reading number 1 when implementation bit 28 is 0 returns 0. Reading any number other than 0, 1 or 25 also returns 0.
- R6: Reading number 25 returns control word bits 31:25 in result bits 7:1 and control word bit 23 in result bit 0. All higher result bits are 0.
- R7: A write to number 1 requests FR=0 and a write to number 4 requests FR=1 (`fr_we` high, new value on `fr_val`). This happens only when implementation bit 28 is 1, `src_idx` is 0 and `sw_enable` is 1.
- R8: Writes to numbers 1 and 4 produce no update and no exception when implementation bit 28 is 0 or `src_idx` is nonzero.
- R9: Writes to numbers 1 and 4 that meet the bit-28 and `src_idx` conditions but have `sw_enable` 0 pulse `exc_ri` and make no FR request.
- R10: A write to number 25 with any of data bits XLEN-1:8 set makes no control word update.
- R11: A write to number 25 with data bits XLEN-1:8 all zero requests a new control word (`csr_we`). Data bits 7:1 go to bits 31:25, data bit 0 goes to bit 23, and every other bit keeps the value of `csr_word`.
- R12: `exc_ri` is high for exactly one cycle per faulting access. In that cycle `rd_vld`, `fr_we` and `csr_we` are all low.
- R13: `mode_chg` pulses together with `fr_we` exactly when the requested FR value differs from `fr_cur`.
- R14: When `rd_en` and `wr_en` are high together, only the read is carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| sel | input | 5 | Control register number |
| src_idx | input | 5 | General-purpose source register index of the write |
| wr_data | input | XLEN | Write data |
| id_word | input | 32 | Implementation word; bit 28 advertises the FR alias |
| csr_word | input | 32 | Current control/status word |
| fr_cur | input | 1 | Current status FR bit |
| sw_enable | input | 1 | Configuration enable for user FR switching |
| rd_data | output | XLEN | Read result, held between reads |
| rd_vld | output | 1 | Read result valid pulse |
| fr_we | output | 1 | FR update request |
| fr_val | output | 1 | Requested FR value |
| mode_chg | output | 1 | Register pairing mode change pulse |
| csr_we | output | 1 | Control word update request |
| csr_val | output | 32 | Requested control word |
| exc_ri | output | 1 | Reserved-instruction exception pulse |

## Verification
The embedded properties take for granted that `fr_cur`, `csr_word` and `id_word` are stable and meaningful in the cycle a strobe is sampled. They also assume the surrounding core applies one requested update before it issues the next dependent access. The stimulus changes every input only on the falling clock edge and holds it through the sampling edge. Its sequences include back-to-back faulting accesses and simultaneous read and write strobes, and all of them stay inside these assumptions.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;
  localparam int unsigned SEL_W        = 5;
  localparam logic [SEL_W-1:0] SEL_IDENT = 5'd0;
  localparam logic [SEL_W-1:0] SEL_FRCLR = 5'd1;
  localparam logic [SEL_W-1:0] SEL_FRSET = 5'd4;
  localparam logic [SEL_W-1:0] SEL_PACK  = 5'd25;
  localparam int unsigned ALIAS_AVAIL_BIT = 28;
  localparam logic [31:0] PACK_MASK = 32'hFE80_0000;

  typedef struct packed {
    logic        fr_we;
    logic        fr_val;
    logic        csr_we;
    logic [31:0] csr_val;
    logic        exc;
  } wr_res_t;
endpackage

// File: rtl/fpctl_rd_dec.sv
module fpctl_rd_dec
  import fpctl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [31:0]      id_word,
  input  logic [31:0]      csr_word,
  input  logic             fr_cur,
  input  logic             sw_enable,
  output logic             vld,
  output logic             exc,
  output logic [XLEN-1:0]  data
);
  logic avail;
  assign avail = id_word[ALIAS_AVAIL_BIT];

  always_comb begin
    vld  = 1'b0;
    exc  = 1'b0;
    data = '0;
    if (en) begin
      vld = 1'b1;
      unique case (sel)
        SEL_IDENT: data = XLEN'(signed'(id_word));
        SEL_FRCLR: begin
          if (avail && sw_enable) begin
            data[0] = fr_cur;
          end else if (avail) begin
            vld = 1'b0;
            exc = 1'b1;
          end
        end
        SEL_PACK: data[7:0] = {csr_word[31:25], csr_word[23]};
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpctl_wr_dec.sv
module fpctl_wr_dec
  import fpctl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [SEL_W-1:0] src_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [31:0]      id_word,
  input  logic [31:0]      csr_word,
  input  logic             sw_enable,
  output wr_res_t          res
);
  logic alias_ok;
  logic hi_clean;
  assign alias_ok = id_word[ALIAS_AVAIL_BIT] && (src_idx == '0);
  assign hi_clean = (wr_data[XLEN-1:8] == '0);

  always_comb begin
    res = '0;
    res.csr_val = csr_word;
    if (en) begin
      if ((sel == SEL_FRCLR) || (sel == SEL_FRSET)) begin
        if (alias_ok) begin
          if (sw_enable) begin
            res.fr_we  = 1'b1;
            res.fr_val = (sel == SEL_FRSET);
          end else begin
            res.exc = 1'b1;
          end
        end
      end else if (sel == SEL_PACK) begin
        if (hi_clean) begin
          res.csr_we = 1'b1;
          res.csr_val[31:25] = wr_data[7:1];
          res.csr_val[23]    = wr_data[0];
        end
      end
    end
  end
endmodule

// File: rtl/fpctl_access.sv
module fpctl_access
  import fpctl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [4:0]      sel,
  input  logic [4:0]      src_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [31:0]     id_word,
  input  logic [31:0]     csr_word,
  input  logic            fr_cur,
  input  logic            sw_enable,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_vld,
  output logic            fr_we,
  output logic            fr_val,
  output logic            mode_chg,
  output logic            csr_we,
  output logic [31:0]     csr_val,
  output logic            exc_ri
);
  logic            do_wr;
  logic            rd_vld_d, rd_exc_d;
  logic [XLEN-1:0] rd_data_d;
  wr_res_t         wres;
  logic            mode_chg_d, exc_d;

  // A simultaneous write strobe yields to the read (R14)
  assign do_wr = wr_en & ~rd_en;

  fpctl_rd_dec #(.XLEN(XLEN)) u_rd (
    .en(rd_en), .sel(sel), .id_word(id_word), .csr_word(csr_word),
    .fr_cur(fr_cur), .sw_enable(sw_enable),
    .vld(rd_vld_d), .exc(rd_exc_d), .data(rd_data_d)
  );

  fpctl_wr_dec #(.XLEN(XLEN)) u_wr (
    .en(do_wr), .sel(sel), .src_idx(src_idx), .wr_data(wr_data),
    .id_word(id_word), .csr_word(csr_word), .sw_enable(sw_enable),
    .res(wres)
  );

  always_comb begin
    mode_chg_d = wres.fr_we && (wres.fr_val != fr_cur);
    exc_d      = rd_exc_d | wres.exc;
  end

  // pulse flags: loaded every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld   <= 1'b0;
      fr_we    <= 1'b0;
      mode_chg <= 1'b0;
      csr_we   <= 1'b0;
      exc_ri   <= 1'b0;
    end else begin
      rd_vld   <= rd_vld_d;
      fr_we    <= wres.fr_we;
      mode_chg <= mode_chg_d;
      csr_we   <= wres.csr_we;
      exc_ri   <= exc_d;
    end
  end

  // data holders: explicit load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      fr_val  <= 1'b0;
      csr_val <= '0;
    end else begin
      if (rd_vld_d)    rd_data <= rd_data_d;
      if (wres.fr_we)  fr_val  <= wres.fr_val;
      if (wres.csr_we) csr_val <= wres.csr_val;
    end
  end

  AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ri |-> !rd_vld && !fr_we && !csr_we); // R12
  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_ri |-> $past(rd_en || wr_en)); // R12
  AST_MODE_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> fr_we && (fr_val != $past(fr_cur))); // R13
  AST_FR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    fr_we |-> ($past(src_idx) == 5'd0) && $past(id_word[ALIAS_AVAIL_BIT]) && $past(sw_enable)); // R7
  AST_PACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we |-> ((csr_val & ~PACK_MASK) == ($past(csr_word) & ~PACK_MASK))); // R11
  AST_WIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && sel == SEL_PACK && wr_data[XLEN-1:8] != '0) |=> !csr_we); // R10
  AST_RD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |=> !fr_we && !csr_we); // R14
  AST_RD_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel != SEL_IDENT && sel != SEL_FRCLR && sel != SEL_PACK) |=> rd_vld && rd_data == '0); // R5
endmodule

// File: tb/fpctl_access_bench.sv
module fpctl_access_bench;
  localparam int XLEN = 32;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rd_en, wr_en, fr_cur, sw_enable;
  logic [4:0]      sel, src_idx;
  logic [XLEN-1:0] wr_data;
  logic [31:0]     id_word, csr_word;
  logic [XLEN-1:0] rd_data;
  logic            rd_vld, fr_we, fr_val, mode_chg, csr_we, exc_ri;
  logic [31:0]     csr_val;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference expectations (held values persist like the outputs)
  logic [XLEN-1:0] e_rd_data;
  logic            e_rd_vld, e_fr_we, e_fr_val, e_mode_chg, e_csr_we, e_exc;
  logic [31:0]     e_csr_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpctl_access #(.XLEN(XLEN)) u_fpctl_access (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
    .src_idx(src_idx), .wr_data(wr_data), .id_word(id_word),
    .csr_word(csr_word), .fr_cur(fr_cur), .sw_enable(sw_enable),
    .rd_data(rd_data), .rd_vld(rd_vld), .fr_we(fr_we), .fr_val(fr_val),
    .mode_chg(mode_chg), .csr_we(csr_we), .csr_val(csr_val), .exc_ri(exc_ri)
  );

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== e_rd_data || rd_vld !== e_rd_vld || fr_we !== e_fr_we ||
        fr_val !== e_fr_val || mode_chg !== e_mode_chg || csr_we !== e_csr_we ||
        csr_val !== e_csr_val || exc_ri !== e_exc) begin
      errors++;
      $display("FAIL %s: got rd=%h v=%b frwe=%b fr=%b mc=%b cwe=%b cv=%h x=%b exp rd=%h v=%b frwe=%b fr=%b mc=%b cwe=%b cv=%h x=%b",
               tag, rd_data, rd_vld, fr_we, fr_val, mode_chg, csr_we, csr_val, exc_ri,
               e_rd_data, e_rd_vld, e_fr_we, e_fr_val, e_mode_chg, e_csr_we, e_csr_val, e_exc);
    end
  endtask

  // Behavioural model of one access, evaluated on the inputs just applied
  task automatic model();
    bit has_alias = id_word[28];
    e_rd_vld = 0; e_fr_we = 0; e_mode_chg = 0; e_csr_we = 0; e_exc = 0;
    if (rd_en) begin
      if (sel == 1 && has_alias && !sw_enable) e_exc = 1;
      else begin
        e_rd_vld = 1;
        if (sel == 0) e_rd_data = XLEN'(signed'(id_word));
        else if (sel == 1) e_rd_data = (has_alias && sw_enable) ? XLEN'(fr_cur) : '0;
        else if (sel == 25) e_rd_data = XLEN'(((csr_word >> 24) & 32'hFE) | ((csr_word >> 23) & 32'h1));
        else e_rd_data = '0;
      end
    end else if (wr_en) begin
      if ((sel == 1 || sel == 4) && has_alias && src_idx == 0) begin
        if (sw_enable) begin
          e_fr_we = 1;
          e_fr_val = (sel == 4);
          e_mode_chg = (e_fr_val != fr_cur);
        end else e_exc = 1;
      end else if (sel == 25 && (wr_data >> 8) == 0) begin
        e_csr_we = 1;
        e_csr_val = (csr_word & ~32'hFE80_0000) | ((32'(wr_data) & 32'hFE) << 24) |
                    ((32'(wr_data) & 32'h1) << 23);
      end
    end
  endtask

  task automatic acc(input bit r, input bit w, input int s, input int src,
                     input logic [XLEN-1:0] d, input logic [31:0] id,
                     input logic [31:0] cw, input bit fr, input bit en,
                     input string tag);
    rd_en = r; wr_en = w; sel = 5'(s); src_idx = 5'(src); wr_data = d;
    id_word = id; csr_word = cw; fr_cur = fr; sw_enable = en;
    model();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [31:0] ID_ON  = 32'h9000_0005; // alias bit 28 set, sign bit set
  localparam logic [31:0] ID_OFF = 32'h8000_0A00;

  initial begin
    rst_n = 0; rd_en = 0; wr_en = 0; sel = 0; src_idx = 0; wr_data = 0;
    id_word = 0; csr_word = 0; fr_cur = 0; sw_enable = 0;
    e_rd_data = 0; e_fr_val = 0; e_csr_val = 0;
    e_rd_vld = 0; e_fr_we = 0; e_mode_chg = 0; e_csr_we = 0; e_exc = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 idle after release");

    acc(1,0,0,0,0,ID_ON,0,0,1,"R2 ident read");
    acc(1,0,0,0,0,ID_OFF,0,0,0,"R2 ident read no alias");
    acc(1,0,1,0,0,ID_ON,0,1,1,"R3 alias read FR=1");
    acc(1,0,1,0,0,ID_ON,0,0,1,"R3 alias read FR=0");
    acc(1,0,1,0,0,ID_ON,0,1,0,"R4 alias read disabled");
    acc(1,0,1,0,0,ID_ON,0,1,0,"R12 back-to-back fault");
    acc(0,0,0,0,0,ID_ON,0,1,0,"R12 pulse ends");
    acc(1,0,1,0,0,ID_OFF,0,1,1,"R5 alias read absent");
    acc(1,0,7,0,0,ID_ON,32'hFFFF_FFFF,1,1,"R5 unlisted read");
    acc(1,0,31,0,0,ID_ON,32'hFFFF_FFFF,1,1,"R5 unlisted read 31");
    acc(1,0,25,0,0,ID_ON,32'hFE80_0000,0,1,"R6 pack all set");
    acc(1,0,25,0,0,ID_ON,32'h017F_FFFF,0,1,"R6 pack complement");
    acc(1,0,25,0,0,ID_ON,32'hA580_0000,0,1,"R6 pack mixed");
    acc(0,1,1,0,0,ID_ON,0,1,1,"R7 clear FR, R13 change");
    acc(0,1,4,0,0,ID_ON,0,0,1,"R7 set FR, R13 change");
    acc(0,1,4,0,0,ID_ON,0,1,1,"R13 set already set");
    acc(0,1,1,0,0,ID_ON,0,0,1,"R13 clear already clear");
    acc(0,1,1,3,0,ID_ON,0,1,1,"R8 nonzero source");
    acc(0,1,4,9,0,ID_ON,0,0,0,"R8 nonzero source disabled");
    acc(0,1,4,0,0,ID_OFF,0,0,1,"R8 alias absent");
    acc(0,1,1,0,0,ID_ON,0,1,0,"R9 clear disabled");
    acc(0,1,4,0,0,ID_ON,0,0,0,"R9 set disabled");
    acc(0,1,25,0,32'h0000_0100,ID_ON,32'h1234_5678,0,1,"R10 wide data");
    acc(0,1,25,0,32'h8000_00FF,ID_ON,32'h1234_5678,0,1,"R10 top bit data");
    acc(0,1,25,0,32'h0000_00AB,ID_ON,32'h0123_4567,0,1,"R11 scatter");
    acc(0,1,25,0,32'h0000_00FF,ID_ON,32'h0000_0000,0,1,"R11 scatter ones");
    acc(0,1,25,0,32'h0000_0000,ID_ON,32'hFFFF_FFFF,0,1,"R11 scatter zeros");
    acc(0,1,7,0,32'h0000_0012,ID_ON,32'hFFFF_FFFF,0,1,"R5 unlisted write");
    acc(1,1,25,0,32'h0000_0055,ID_ON,32'hFE80_0000,0,1,"R14 read wins pack");
    acc(1,1,4,0,0,ID_ON,0,0,1,"R14 read wins alias");
    for (int i = 0; i < 40; i++) begin
      acc(i[0], ~i[0], (i % 3 == 0) ? 25 : ((i % 3 == 1) ? 1 : 4), (i % 5 == 0) ? 2 : 0,
          XLEN'(i * 37) & 32'h1FF, (i % 7 == 0) ? ID_OFF : ID_ON,
          32'h9E3779B9 ^ (32'(i) << 20), i[1], i[2], "R11 R7 mixed sweep");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule